// File: doc/BRIEF.md
# JTAG Debug Transaction Monitor

This block watches a stream of completed JTAG scans and turns them into decoded debug-port transaction records. An upstream TAP follower gives it a one-cycle strobe each time an instruction scan finishes, with the bits shifted in, and a strobe each time a data scan finishes, with the bits shifted in, the bits shifted out, and the scan length. The monitor never drives the JTAG wires. It only observes and classifies.

An instruction scan arms the monitor with the register that the instruction selects. The next data scan is then decoded according to that register and reported as one record with a single-cycle valid pulse. The monitor then disarms. For the bypass register the record comes from the incoming bits. For the identification, debug-port access, access-port access, abort and unrecognised registers it comes from the outgoing bits, with the request address and direction taken from the incoming bits. A length check flags data scans whose bit count does not match the selected register.

Top module: `jtag_dbg_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `sel_valid`, `rec_valid`, `len_err`, `abort_warn` and all record fields read zero.
- R2: A cycle with `ir_done` high gives `sel_valid` high in the next cycle only. `sel_kind` holds the kind chosen by `ir_shift[3:0]`: 4'b1111 gives 0 (bypass), 4'b1110 gives 1 (identification), 4'b1010 gives 2 (debug-port access), 4'b1011 gives 3 (access-port access), 4'b1000 gives 4 (abort), and every other code gives 5 (unknown).
- R3: A data scan that arrives while the monitor is not armed produces no record: `rec_valid` stays low in the next cycle.
- R4: A data scan that arrives while the monitor is armed gives `rec_valid` high for exactly the next cycle. `rec_kind` equals the armed kind.
- R5: Each instruction scan arms the monitor for exactly one data scan. A second data scan without a new instruction scan produces no record.
- R6: A bypass record has `rec_data = {31'b0, dr_in[0]}`. All other fields are zero.
- R7: An access record (kind 2 or 3) has `rec_data = dr_out[34:3]`, `rec_ack = dr_out[2:0]`, `rec_wdata = dr_in[34:3]`, `rec_addr = dr_in[2:1]` and `rec_rnw = dr_in[0]`. The identification and abort fields are zero.
- R8: An identification record has `rec_data = dr_out[31:0]`, `id_version = dr_out[31:28]`, `id_part = dr_out[27:12]`, `id_maker = dr_out[11:1]` and `id_rsvd = dr_out[0]`. The access fields are zero.
- R9: An abort record has `rec_data = dr_out[31:0]` and `abort_bit = dr_out[0]`. `abort_warn` is high exactly when `dr_out[31:1]` is nonzero. No other kind raises `abort_warn` or `abort_bit`.
- R10: An unknown record has `rec_data = dr_out[31:0]`. All other fields are zero.
- R11: `len_err` is high in a record when `dr_count` differs from the expected length: bypass 1, identification 32, access and abort 35. An unknown record never raises `len_err`.
- R12: A new instruction scan replaces any armed kind. When `ir_done` and `dr_done` are high in the same cycle, the data scan is decoded with the kind armed before that cycle (or dropped if not armed), and the instruction arms the next data scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_done | input | 1 | One-cycle strobe: an instruction scan finished |
| ir_shift | input | IR_W | Bits shifted in during that instruction scan |
| dr_done | input | 1 | One-cycle strobe: a data scan finished |
| dr_in | input | 35 | Bits shifted in during the data scan |
| dr_out | input | 35 | Bits shifted out during the data scan |
| dr_count | input | LEN_W | Number of bits in the data scan |
| sel_valid | output | 1 | Pulse: a register kind was selected |
| sel_kind | output | 3 | Selected register kind |
| rec_valid | output | 1 | Pulse: a new record is on the record outputs |
| rec_kind | output | 3 | Register kind of the record |
| rec_data | output | 32 | Decoded data word |
| rec_wdata | output | 32 | Request data shifted in (access kinds) |
| rec_addr | output | 2 | Register address (access kinds) |
| rec_rnw | output | 1 | 1 = read request, 0 = write request (access kinds) |
| rec_ack | output | 3 | Acknowledge code (access kinds) |
| id_version | output | 4 | Version field (identification) |
| id_part | output | 16 | Part number field (identification) |
| id_maker | output | 11 | Manufacturer field (identification) |
| id_rsvd | output | 1 | Reserved bit (identification) |
| abort_bit | output | 1 | Abort request bit (abort kind) |
| abort_warn | output | 1 | Reserved abort bits were nonzero |
| len_err | output | 1 | Scan length did not match the register |

## Verification
Two functions can fall in the same cycle: reporting a new selection and decoding a data scan. This happens when `ir_done` and `dr_done` strobe together. The bench provokes this both with the monitor armed and with it idle. It judges that the record carries the previously armed kind while `sel_kind` already shows the new one, that the idle case yields a selection and no record, and that the following data scan decodes under the new kind. The bench also checks that an instruction scan with no data scan in between replaces the armed kind.

// File: rtl/jdm_pkg.sv
package jdm_pkg;

    localparam int IR_KEY_W = 4;
    localparam int DR_MAX_W = 35;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int ACK_W    = 3;

    localparam logic [IR_KEY_W-1:0] CODE_BYPASS = 4'b1111;
    localparam logic [IR_KEY_W-1:0] CODE_IDENT  = 4'b1110;
    localparam logic [IR_KEY_W-1:0] CODE_DPORT  = 4'b1010;
    localparam logic [IR_KEY_W-1:0] CODE_APORT  = 4'b1011;
    localparam logic [IR_KEY_W-1:0] CODE_ABORT  = 4'b1000;

    typedef enum logic [2:0] {
        K_BYPASS  = 3'd0,
        K_IDENT   = 3'd1,
        K_DPORT   = 3'd2,
        K_APORT   = 3'd3,
        K_ABORT   = 3'd4,
        K_UNKNOWN = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [WORD_W-1:0]   data;
        logic [WORD_W-1:0]   wdata;
        logic [ADDR_W-1:0]   addr;
        logic                rnw;
        logic [ACK_W-1:0]    ack;
        logic [3:0]          ver;
        logic [15:0]         part;
        logic [10:0]         maker;
        logic                rsvd;
        logic                abort_bit;
        logic                abort_warn;
        logic                len_err;
    } rec_t;

    function automatic int unsigned kind_len(kind_e k);
        case (k)
            K_BYPASS: return 1;
            K_IDENT:  return WORD_W;
            K_DPORT,
            K_APORT,
            K_ABORT:  return DR_MAX_W;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/jdm_ir_decode.sv
module jdm_ir_decode
    import jdm_pkg::*;
(
    input  logic [IR_KEY_W-1:0] code,
    output kind_e               kind
);
    always_comb begin
        case (code)
            CODE_BYPASS: kind = K_BYPASS;
            CODE_IDENT:  kind = K_IDENT;
            CODE_DPORT:  kind = K_DPORT;
            CODE_APORT:  kind = K_APORT;
            CODE_ABORT:  kind = K_ABORT;
            default:     kind = K_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/jdm_field_unpack.sv
module jdm_field_unpack
    import jdm_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  kind_e               kind,
    input  logic [DR_MAX_W-1:0] tdi,
    input  logic [DR_MAX_W-1:0] tdo,
    input  logic [LEN_W-1:0]    len,
    output rec_t                rec
);
    always_comb begin
        rec         = '0;
        rec.kind    = kind;
        rec.len_err = (kind != K_UNKNOWN) && (len != LEN_W'(kind_len(kind)));
        case (kind)
            K_BYPASS: begin
                rec.data = {{(WORD_W-1){1'b0}}, tdi[0]};
            end
            K_IDENT: begin
                rec.data  = tdo[WORD_W-1:0];
                rec.ver   = tdo[31:28];
                rec.part  = tdo[27:12];
                rec.maker = tdo[11:1];
                rec.rsvd  = tdo[0];
            end
            K_DPORT, K_APORT: begin
                rec.data  = tdo[DR_MAX_W-1:ACK_W];
                rec.ack   = tdo[ACK_W-1:0];
                rec.wdata = tdi[DR_MAX_W-1:ACK_W];
                rec.addr  = tdi[ADDR_W:1];
                rec.rnw   = tdi[0];
            end
            K_ABORT: begin
                rec.data       = tdo[WORD_W-1:0];
                rec.abort_bit  = tdo[0];
                rec.abort_warn = |tdo[WORD_W-1:1];
            end
            default: begin
                rec.data = tdo[WORD_W-1:0];
            end
        endcase
    end
endmodule

// File: rtl/jtag_dbg_monitor.sv
module jtag_dbg_monitor
    import jdm_pkg::*;
#(
    parameter int IR_W  = 4,
    parameter int LEN_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ir_done,
    input  logic [IR_W-1:0]     ir_shift,
    input  logic                dr_done,
    input  logic [DR_MAX_W-1:0] dr_in,
    input  logic [DR_MAX_W-1:0] dr_out,
    input  logic [LEN_W-1:0]    dr_count,
    output logic                sel_valid,
    output logic [2:0]          sel_kind,
    output logic                rec_valid,
    output logic [2:0]          rec_kind,
    output logic [WORD_W-1:0]   rec_data,
    output logic [WORD_W-1:0]   rec_wdata,
    output logic [ADDR_W-1:0]   rec_addr,
    output logic                rec_rnw,
    output logic [ACK_W-1:0]    rec_ack,
    output logic [3:0]          id_version,
    output logic [15:0]         id_part,
    output logic [10:0]         id_maker,
    output logic                id_rsvd,
    output logic                abort_bit,
    output logic                abort_warn,
    output logic                len_err
);
    kind_e ir_kind;
    kind_e kind_q;
    logic  armed_q;
    rec_t  rec_next;
    rec_t  rec_q;
    logic  rec_v_q;
    logic  sel_v_q;
    kind_e sel_q;
    logic  take_dr;

    jdm_ir_decode u_ir (
        .code (ir_shift[IR_KEY_W-1:0]),
        .kind (ir_kind)
    );

    jdm_field_unpack #(.LEN_W(LEN_W)) u_unpack (
        .kind (kind_q),
        .tdi  (dr_in),
        .tdo  (dr_out),
        .len  (dr_count),
        .rec  (rec_next)
    );

    assign take_dr = dr_done && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            kind_q  <= K_BYPASS;
        end else if (ir_done) begin
            armed_q <= 1'b1;
            kind_q  <= ir_kind;
        end else if (dr_done) begin
            armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_v_q <= 1'b0;
            sel_q   <= K_BYPASS;
            rec_v_q <= 1'b0;
            rec_q   <= '0;
        end else begin
            sel_v_q <= ir_done;
            rec_v_q <= take_dr;
            if (ir_done) sel_q <= ir_kind;
            if (take_dr) rec_q <= rec_next;
        end
    end

    assign sel_valid  = sel_v_q;
    assign sel_kind   = sel_q;
    assign rec_valid  = rec_v_q;
    assign rec_kind   = rec_q.kind;
    assign rec_data   = rec_q.data;
    assign rec_wdata  = rec_q.wdata;
    assign rec_addr   = rec_q.addr;
    assign rec_rnw    = rec_q.rnw;
    assign rec_ack    = rec_q.ack;
    assign id_version = rec_q.ver;
    assign id_part    = rec_q.part;
    assign id_maker   = rec_q.maker;
    assign id_rsvd    = rec_q.rsvd;
    assign abort_bit  = rec_q.abort_bit;
    assign abort_warn = rec_q.abort_warn;
    assign len_err    = rec_q.len_err;
endmodule

// File: rtl/jdm_checker.sv
module jdm_checker (
    input logic        clk,
    input logic        rst,
    input logic        ir_done,
    input logic        dr_done,
    input logic        armed,
    input logic        sel_valid,
    input logic        rec_valid,
    input logic [2:0]  rec_kind,
    input logic [30:0] rec_data_hi,
    input logic [1:0]  rec_addr,
    input logic        abort_warn,
    input logic        len_err
);
    p_sel_follows_ir_r2: assert property (@(posedge clk) disable iff (rst)
        ir_done |=> sel_valid);

    p_sel_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> $past(ir_done));

    p_idle_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (dr_done && !armed) |=> !rec_valid);

    p_rec_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> ($past(dr_done) && $past(armed)));

    p_one_scan_r5: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !$past(ir_done)) |=> !rec_valid);

    p_bypass_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_kind == 3'd0) |-> (rec_data_hi == '0 && rec_addr == '0));

    p_warn_abort_only_r9: assert property (@(posedge clk) disable iff (rst)
        abort_warn |-> (rec_kind == 3'd4));

    p_unknown_no_len_r11: assert property (@(posedge clk) disable iff (rst)
        (rec_kind == 3'd5) |-> !len_err);
endmodule

bind jtag_dbg_monitor jdm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ir_done     (ir_done),
    .dr_done     (dr_done),
    .armed       (armed_q),
    .sel_valid   (sel_valid),
    .rec_valid   (rec_valid),
    .rec_kind    (rec_kind),
    .rec_data_hi (rec_data[31:1]),
    .rec_addr    (rec_addr),
    .abort_warn  (abort_warn),
    .len_err     (len_err)
);

// File: tb/sim_jtag_dbg_monitor.sv
module sim_jtag_dbg_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_done = 1'b0;
    logic [3:0]  ir_shift = '0;
    logic        dr_done = 1'b0;
    logic [34:0] dr_in = '0;
    logic [34:0] dr_out = '0;
    logic [5:0]  dr_count = '0;
    logic        sel_valid, rec_valid, rec_rnw, id_rsvd, abort_bit, abort_warn, len_err;
    logic [2:0]  sel_kind, rec_kind, rec_ack;
    logic [31:0] rec_data, rec_wdata;
    logic [1:0]  rec_addr;
    logic [3:0]  id_version;
    logic [15:0] id_part;
    logic [10:0] id_maker;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    jtag_dbg_monitor u0 (
        .clk(clk), .rst(rst), .ir_done(ir_done), .ir_shift(ir_shift),
        .dr_done(dr_done), .dr_in(dr_in), .dr_out(dr_out), .dr_count(dr_count),
        .sel_valid(sel_valid), .sel_kind(sel_kind), .rec_valid(rec_valid),
        .rec_kind(rec_kind), .rec_data(rec_data), .rec_wdata(rec_wdata),
        .rec_addr(rec_addr), .rec_rnw(rec_rnw), .rec_ack(rec_ack),
        .id_version(id_version), .id_part(id_part), .id_maker(id_maker),
        .id_rsvd(id_rsvd), .abort_bit(abort_bit), .abort_warn(abort_warn),
        .len_err(len_err)
    );

    function automatic logic [2:0] exp_kind(input logic [3:0] c);
        case (c)
            4'b1111: return 3'd0;
            4'b1110: return 3'd1;
            4'b1010: return 3'd2;
            4'b1011: return 3'd3;
            4'b1000: return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic [5:0] exp_len(input logic [2:0] k);
        case (k)
            3'd0:    return 6'd1;
            3'd1:    return 6'd32;
            3'd5:    return 6'd0;
            default: return 6'd35;
        endcase
    endfunction

    function automatic logic [34:0] next_word();
        logic [31:0] a;
        seed = seed * 32'd1103515245 + 32'd12345;
        a    = seed;
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[18:16], a ^ {seed[15:0], seed[31:16]}};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit do_ir, input logic [3:0] code, input bit do_dr,
                         input logic [34:0] ti, input logic [34:0] to, input logic [5:0] len);
        @(negedge clk);
        ir_done  = do_ir;
        ir_shift = code;
        dr_done  = do_dr;
        dr_in    = ti;
        dr_out   = to;
        dr_count = len;
        @(negedge clk);
        ir_done = 1'b0;
        dr_done = 1'b0;
    endtask

    task automatic arm(input logic [3:0] code);
        drive(1'b1, code, 1'b0, '0, '0, '0);
        chk(sel_valid == 1'b1, "R2", "sel_valid", 64'(sel_valid), 64'd1);
        chk(sel_kind == exp_kind(code), "R2", "sel_kind", 64'(sel_kind), 64'(exp_kind(code)));
    endtask

    task automatic check_rec(input logic [2:0] k, input logic [34:0] ti,
                             input logic [34:0] to, input logic [5:0] len);
        logic [31:0] e_data = '0, e_wdata = '0;
        logic [1:0]  e_addr = '0;
        logic        e_rnw = 1'b0, e_rsvd = 1'b0, e_ab = 1'b0, e_warn = 1'b0, e_len;
        logic [2:0]  e_ack = '0;
        logic [3:0]  e_ver = '0;
        logic [15:0] e_part = '0;
        logic [10:0] e_mk = '0;
        string req;
        e_len = (k != 3'd5) && (len != exp_len(k));
        case (k)
            3'd0: begin req = "R6"; e_data = {31'b0, ti[0]}; end
            3'd1: begin
                req = "R8"; e_data = to[31:0]; e_ver = to[31:28];
                e_part = to[27:12]; e_mk = to[11:1]; e_rsvd = to[0];
            end
            3'd2, 3'd3: begin
                req = "R7"; e_data = to[34:3]; e_ack = to[2:0];
                e_wdata = ti[34:3]; e_addr = ti[2:1]; e_rnw = ti[0];
            end
            3'd4: begin
                req = "R9"; e_data = to[31:0]; e_ab = to[0]; e_warn = |to[31:1];
            end
            default: begin req = "R10"; e_data = to[31:0]; end
        endcase
        chk(rec_valid == 1'b1, "R4", "rec_valid", 64'(rec_valid), 64'd1);
        chk(rec_kind == k, "R4", "rec_kind", 64'(rec_kind), 64'(k));
        chk(rec_data == e_data, req, "rec_data", 64'(rec_data), 64'(e_data));
        chk(rec_wdata == e_wdata, req, "rec_wdata", 64'(rec_wdata), 64'(e_wdata));
        chk({rec_addr, rec_rnw, rec_ack} == {e_addr, e_rnw, e_ack}, req, "addr/rnw/ack",
            64'({rec_addr, rec_rnw, rec_ack}), 64'({e_addr, e_rnw, e_ack}));
        chk({id_version, id_part, id_maker, id_rsvd} == {e_ver, e_part, e_mk, e_rsvd}, req,
            "id fields", 64'({id_version, id_part, id_maker, id_rsvd}),
            64'({e_ver, e_part, e_mk, e_rsvd}));
        chk({abort_bit, abort_warn} == {e_ab, e_warn}, "R9", "abort/warn",
            64'({abort_bit, abort_warn}), 64'({e_ab, e_warn}));
        chk(len_err == e_len, "R11", "len_err", 64'(len_err), 64'(e_len));
    endtask

    task automatic dr_scan_check(input logic [2:0] k, input logic [34:0] ti,
                                 input logic [34:0] to, input logic [5:0] len);
        drive(1'b0, 4'b0000, 1'b1, ti, to, len);
        check_rec(k, ti, to, len);
    endtask

    task automatic dr_scan_none(input string req);
        drive(1'b0, 4'b0000, 1'b1, next_word(), next_word(), 6'd35);
        chk(rec_valid == 1'b0, req, "rec_valid (no record)", 64'(rec_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [34:0] ti, to;
        logic [2:0]  k;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({sel_valid, rec_valid, len_err, abort_warn} == 4'b0, "R1", "valids in reset",
            64'({sel_valid, rec_valid, len_err, abort_warn}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(rec_data == '0 && rec_kind == '0 && rec_wdata == '0, "R1", "record after reset",
            64'(rec_data), 64'd0);
        chk(sel_valid == 1'b0 && rec_valid == 1'b0, "R1", "valids after reset",
            64'({sel_valid, rec_valid}), 64'd0);

        // R3 data scans in idle are dropped
        dr_scan_none("R3");
        dr_scan_none("R3");

        // Sweep every instruction code, several data patterns each
        for (int c = 0; c < 16; c++) begin
            k = exp_kind(4'(c));
            for (int v = 0; v < 4; v++) begin
                arm(4'(c));
                ti = next_word();
                to = next_word();
                dr_scan_check(k, ti, to, exp_len(k));
            end
            // R5 only one data scan per instruction
            dr_scan_none("R5");
        end

        // R9 abort reserved-bit boundaries
        arm(4'b1000);
        dr_scan_check(3'd4, '0, 35'h0_0000_0001, 6'd35);
        arm(4'b1000);
        dr_scan_check(3'd4, '0, 35'h0_0000_0002, 6'd35);
        arm(4'b1000);
        dr_scan_check(3'd4, '0, 35'h7_0000_0000, 6'd35);
        arm(4'b1000);
        dr_scan_check(3'd4, '0, 35'h0_8000_0000, 6'd35);

        // R11 length mismatch per kind
        for (int c = 0; c < 16; c++) begin
            k = exp_kind(4'(c));
            for (int d = -1; d <= 1; d++) begin
                arm(4'(c));
                dr_scan_check(k, next_word(), next_word(), 6'(int'(exp_len(k)) + d));
            end
        end

        // R12 new instruction replaces an armed kind
        arm(4'b1010);
        arm(4'b1110);
        ti = next_word(); to = next_word();
        dr_scan_check(3'd1, ti, to, 6'd32);

        // R12 instruction and data in the same cycle while armed
        arm(4'b1011);
        ti = next_word(); to = next_word();
        drive(1'b1, 4'b1111, 1'b1, ti, to, 6'd35);
        chk(sel_valid == 1'b1 && sel_kind == 3'd0, "R12", "sel with overlap",
            64'({sel_valid, sel_kind}), 64'({1'b1, 3'd0}));
        check_rec(3'd3, ti, to, 6'd35);
        ti = next_word(); to = next_word();
        dr_scan_check(3'd0, ti, to, 6'd1);
        dr_scan_none("R5");

        // R12 instruction and data in the same cycle while idle
        ti = next_word(); to = next_word();
        drive(1'b1, 4'b1000, 1'b1, ti, to, 6'd35);
        chk(rec_valid == 1'b0, "R12", "idle overlap drops data", 64'(rec_valid), 64'd0);
        chk(sel_valid == 1'b1 && sel_kind == 3'd4, "R12", "idle overlap selects",
            64'({sel_valid, sel_kind}), 64'({1'b1, 3'd4}));
        ti = next_word(); to = next_word();
        dr_scan_check(3'd4, ti, to, 6'd35);

        // R2 / R4 pulses last one cycle
        @(negedge clk);
        chk(sel_valid == 1'b0 && rec_valid == 1'b0, "R4", "pulses end",
            64'({sel_valid, rec_valid}), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule